// File: doc/BRIEF.md
# Parallel Speculative Canonical Huffman Decoder

This block turns a canonical, length-limited prefix-code bitstream back into symbols at up to four symbols per clock. It keeps a left-aligned buffer of stream bits and treats the sixteen leading bit positions of that buffer as candidate code starts. A small arithmetic decoder at each position works out the code length and the canonical index of the code found there, all in the same cycle. A link chaser then starts at position 0, jumps by each decoded length in turn, and keeps up to four decodes that lie on this true boundary chain. Every other speculative result is dropped. The buffer then shifts by the total accepted length and refills from a 32-bit word stream.

Software first loads the code description. For every length from 1 to 12 it writes the first canonical value, the number of codes and the base index into a 256-entry symbol table, and then it fills the table. A start pulse carries the exact bit length of the stream. Decoding runs only after that pulse and stops on the last code, even when that code ends in the middle of a buffered word. Accepted symbols leave through a registered output with valid/ready and a lane count.

Top module: `huff_spec_dec`

## Requirements
- R1: For each length L (1..12), a code of L bits whose value v meets first(L) <= v < first(L)+count(L) decodes to table[base(L) + v - first(L)]. When several lengths match, the shortest one is taken. Lengths are written with cfg_len_sel = L. Table entries are written at cfg_sym_addr.
- R2: Stream bits are consumed most significant bit first within each in_data word, and words are consumed in arrival order.
- R3: While out_valid is high, out_count is between 1 and 4. Lane k, at out_syms bits [8k+7:8k], holds the k-th symbol of the batch in stream order, and lane 0 is the earliest. While out_valid is low, out_count is 0.
- R4: A decode is accepted only if its start position, measured from the current buffer head, is below 16. The next start is the previous start plus the previous code length. The buffer advances by the sum of the accepted lengths.
- R5: in_ready and out_valid stay low until cfg_start is pulsed while idle. busy rises only in the cycle after such a pulse.
- R6: Exactly the codes inside the first cfg_total_bits stream bits are emitted, with no symbol before or after them. busy falls once the last code has been taken.
- R7: While out_valid is high and out_ready is low, out_valid, out_count and out_syms hold their values in the next cycle, and nothing is lost.
- R8: in_ready is high only while busy, when the buffer has room for a whole word and fewer than cfg_total_bits bits have been received. No word beyond the stream length is accepted.
- R9: After reset, out_valid, out_count, in_ready and busy are all zero.
- R10: When codes are short enough that four chained starts fall below 16, a single cycle emits four symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_we | input | 1 | Write strobe for one per-length entry |
| cfg_len_sel | input | 4 | Code length being written (1..12) |
| cfg_first | input | 12 | First canonical value of that length |
| cfg_count | input | 9 | Number of codes of that length |
| cfg_base | input | 8 | Table index of the first code of that length |
| cfg_sym_we | input | 1 | Symbol table write strobe |
| cfg_sym_addr | input | 8 | Symbol table index |
| cfg_sym_data | input | 8 | Symbol value |
| cfg_start | input | 1 | Start pulse; accepted only while idle |
| cfg_total_bits | input | 32 | Stream length in bits, captured at start |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word, first stream bit in bit 31 |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Symbol batch valid |
| out_ready | input | 1 | Sink accepts the batch |
| out_count | output | 3 | Number of valid lanes (0..4) |
| out_syms | output | 32 | Four 8-bit lanes, lane 0 in the low byte |
| busy | output | 1 | Stream decode in progress |

## Verification
The bench uses the default build: 16 candidate offsets, 4 output lanes, 12-bit maximum code length, 8-bit symbols and a 32-bit input word. This build allows a full 256-entry alphabet. A flat 12-bit code forces the offset limit to cut every batch at two symbols. A 1-bit code saturates all four lanes. Random alphabets and stream lengths make the last code end inside a word, with random padding bits after it. Random input gaps and output back-pressure exercise both stall paths.

// File: rtl/huff_pkg.sv
package huff_pkg;
    localparam int HD_MAX_LEN = 12;
    localparam int HD_N_OFF   = 16;
    localparam int HD_LANES   = 4;
    localparam int HD_SYM_W   = 8;
    localparam int HD_IN_W    = 32;
    localparam int HD_CNT_W   = 32;
endpackage

// File: rtl/huff_slot_dec.sv
module huff_slot_dec #(
    parameter int MAX_LEN = 12,
    parameter int SYM_W   = 8,
    parameter int LEN_W   = 4
) (
    input  logic [MAX_LEN-1:0] win_i,
    input  logic [MAX_LEN-1:0] first_i [MAX_LEN],
    input  logic [SYM_W:0]     cnt_i   [MAX_LEN],
    input  logic [SYM_W-1:0]   base_i  [MAX_LEN],
    output logic [LEN_W-1:0]   len_o,
    output logic [SYM_W-1:0]   idx_o
);
    localparam int CW = ((MAX_LEN > SYM_W) ? MAX_LEN : SYM_W) + 1;

    logic [CW-1:0] code;
    logic [CW-1:0] lo;
    logic [CW-1:0] diff;

    // Scan longest to shortest so the shortest matching length wins.
    always_comb begin
        len_o = LEN_W'(MAX_LEN);
        idx_o = '0;
        code  = '0;
        lo    = '0;
        diff  = '0;
        for (int l = MAX_LEN; l >= 1; l--) begin
            code = CW'(win_i >> (MAX_LEN - l));
            lo   = CW'(first_i[l-1]);
            diff = code - lo;
            if (code >= lo && diff < CW'(cnt_i[l-1])) begin
                len_o = LEN_W'(l);
                idx_o = base_i[l-1] + SYM_W'(diff);
            end
        end
    end
endmodule

// File: rtl/huff_chain.sv
module huff_chain #(
    parameter int N_OFF = 16,
    parameter int LANES = 4,
    parameter int LEN_W = 4,
    parameter int POS_W = 5,
    parameter int OFF_W = 4
) (
    input  logic [LEN_W-1:0] len_i [N_OFF],
    output logic [POS_W-1:0] pos_o [LANES],
    output logic [POS_W-1:0] end_o [LANES],
    output logic             ok_o  [LANES]
);
    logic [POS_W-1:0] p;

    // Follow true boundaries from offset 0; a start past the window freezes the chain.
    always_comb begin
        p = '0;
        for (int k = 0; k < LANES; k++) begin
            pos_o[k] = p;
            ok_o[k]  = (p < POS_W'(N_OFF));
            end_o[k] = ok_o[k] ? (p + POS_W'(len_i[p[OFF_W-1:0]])) : p;
            p        = end_o[k];
        end
    end
endmodule

// File: rtl/huff_spec_dec.sv
module huff_spec_dec #(
    parameter int MAX_LEN = huff_pkg::HD_MAX_LEN,
    parameter int N_OFF   = huff_pkg::HD_N_OFF,
    parameter int LANES   = huff_pkg::HD_LANES,
    parameter int SYM_W   = huff_pkg::HD_SYM_W,
    parameter int IN_W    = huff_pkg::HD_IN_W,
    parameter int CNT_W   = huff_pkg::HD_CNT_W,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int OC_W   = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_len_we,
    input  logic [LEN_W-1:0]       cfg_len_sel,
    input  logic [MAX_LEN-1:0]     cfg_first,
    input  logic [SYM_W:0]         cfg_count,
    input  logic [SYM_W-1:0]       cfg_base,
    input  logic                   cfg_sym_we,
    input  logic [SYM_W-1:0]       cfg_sym_addr,
    input  logic [SYM_W-1:0]       cfg_sym_data,
    input  logic                   cfg_start,
    input  logic [CNT_W-1:0]       cfg_total_bits,
    input  logic                   in_valid,
    input  logic [IN_W-1:0]        in_data,
    output logic                   in_ready,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [OC_W-1:0]        out_count,
    output logic [LANES*SYM_W-1:0] out_syms,
    output logic                   busy
);
    localparam int POS_W  = $clog2(N_OFF + MAX_LEN);
    localparam int OFF_W  = $clog2(N_OFF);
    localparam int WIN    = N_OFF + MAX_LEN - 1;
    localparam int BUF_W  = IN_W + WIN;
    localparam int FILL_W = $clog2(BUF_W + 1);
    localparam int NSYM   = 1 << SYM_W;

    typedef struct packed {
        logic                        run;
        logic [CNT_W-1:0]            total;
        logic [CNT_W-1:0]            cns;
        logic [FILL_W-1:0]           fill;
        logic [BUF_W-1:0]            bits;
        logic                        ov;
        logic [OC_W-1:0]             ocnt;
        logic [LANES-1:0][SYM_W-1:0] osym;
    } st_t;

    st_t st_d, st_q;

    logic [MAX_LEN-1:0] first_q  [MAX_LEN];
    logic [SYM_W:0]     cnt_q    [MAX_LEN];
    logic [SYM_W-1:0]   base_q   [MAX_LEN];
    logic [SYM_W-1:0]   symtab_q [NSYM];

    // Code description storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < MAX_LEN; l++) begin
                first_q[l] <= '0;
                cnt_q[l]   <= '0;
                base_q[l]  <= '0;
            end
            for (int s = 0; s < NSYM; s++) symtab_q[s] <= '0;
        end else begin
            if (cfg_len_we && cfg_len_sel != '0 && cfg_len_sel <= LEN_W'(MAX_LEN)) begin
                first_q[cfg_len_sel - 1'b1] <= cfg_first;
                cnt_q[cfg_len_sel - 1'b1]   <= cfg_count;
                base_q[cfg_len_sel - 1'b1]  <= cfg_base;
            end
            if (cfg_sym_we) symtab_q[cfg_sym_addr] <= cfg_sym_data;
        end
    end

    // Speculative decode at every candidate offset.
    logic [LEN_W-1:0] slot_len [N_OFF];
    logic [SYM_W-1:0] slot_idx [N_OFF];

    for (genvar o = 0; o < N_OFF; o++) begin : g_slot
        huff_slot_dec #(.MAX_LEN(MAX_LEN), .SYM_W(SYM_W), .LEN_W(LEN_W)) u_slot (
            .win_i   (st_q.bits[BUF_W-1-o -: MAX_LEN]),
            .first_i (first_q),
            .cnt_i   (cnt_q),
            .base_i  (base_q),
            .len_o   (slot_len[o]),
            .idx_o   (slot_idx[o])
        );
    end

    logic [POS_W-1:0] lane_pos [LANES];
    logic [POS_W-1:0] lane_end [LANES];
    logic             lane_ok  [LANES];

    huff_chain #(.N_OFF(N_OFF), .LANES(LANES), .LEN_W(LEN_W), .POS_W(POS_W), .OFF_W(OFF_W)) u_chain (
        .len_i (slot_len),
        .pos_o (lane_pos),
        .end_o (lane_end),
        .ok_o  (lane_ok)
    );

    logic [CNT_W-1:0]            rem, need;
    logic                        enough, slot_free, go, fire, in_rdy;
    logic [OC_W-1:0]             n_acc;
    logic [POS_W-1:0]            cons, cons_eff;
    logic [LANES-1:0][SYM_W-1:0] lane_sym;

    assign in_rdy = st_q.run && (st_q.fill <= FILL_W'(BUF_W - IN_W))
                    && ((st_q.cns + CNT_W'(st_q.fill)) < st_q.total);

    always_comb begin
        st_d      = st_q;
        rem       = st_q.total - st_q.cns;
        need      = (rem < CNT_W'(WIN)) ? rem : CNT_W'(WIN);
        enough    = CNT_W'(st_q.fill) >= need;
        slot_free = !st_q.ov || out_ready;
        go        = st_q.run && enough && slot_free && (rem != '0);
        n_acc     = '0;
        cons      = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_ok[k] && (CNT_W'(lane_pos[k]) < rem)) begin
                n_acc = OC_W'(k + 1);
                cons  = lane_end[k];
            end
            lane_sym[k] = symtab_q[slot_idx[lane_pos[k][OFF_W-1:0]]];
        end
        cons_eff = go ? cons : '0;
        fire     = in_valid && in_rdy;

        st_d.bits = (st_q.bits << cons_eff)
                  | (fire ? ({in_data, {(BUF_W-IN_W){1'b0}}} >> (st_q.fill - FILL_W'(cons_eff)))
                          : {BUF_W{1'b0}});
        st_d.fill = st_q.fill - FILL_W'(cons_eff) + (fire ? FILL_W'(IN_W) : {FILL_W{1'b0}});
        st_d.cns  = st_q.cns + CNT_W'(cons_eff);
        if (go && CNT_W'(cons) == rem) st_d.run = 1'b0;

        if (slot_free) begin
            st_d.ov   = go;
            st_d.ocnt = go ? n_acc : '0;
            st_d.osym = go ? lane_sym : st_q.osym;
        end

        if (cfg_start && !st_q.run) begin
            st_d.run   = (cfg_total_bits != '0);
            st_d.total = cfg_total_bits;
            st_d.cns   = '0;
            st_d.fill  = '0;
            st_d.bits  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = in_rdy;
    assign out_valid = st_q.ov;
    assign out_count = st_q.ocnt;
    assign out_syms  = st_q.osym;
    assign busy      = st_q.run;
endmodule

// File: rtl/huff_spec_dec_chk.sv
module huff_spec_dec_chk #(
    parameter int LANES = 4,
    parameter int SYM_W = 8,
    parameter int OC_W  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_start,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [OC_W-1:0]        out_count,
    input logic [LANES*SYM_W-1:0] out_syms,
    input logic                   busy
);
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= OC_W'(1) && out_count <= OC_W'(LANES))) else $error("cnt range"); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_count == '0)) else $error("idle count"); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_count) && $stable(out_syms))) else $error("stall"); // R7
    AST_IDLE_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready) else $error("idle ready"); // R8
    AST_OUT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(busy)) else $error("out before run"); // R5
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_start)) else $error("busy w/o start"); // R5
endmodule

bind huff_spec_dec huff_spec_dec_chk #(.LANES(LANES), .SYM_W(SYM_W), .OC_W(OC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_count (out_count),
    .out_syms  (out_syms),
    .busy      (busy)
);

// File: tb/tb_huff_spec_dec.sv
module tb_huff_spec_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_len_we = 1'b0;
    logic [3:0]  cfg_len_sel = '0;
    logic [11:0] cfg_first = '0;
    logic [8:0]  cfg_count = '0;
    logic [7:0]  cfg_base = '0;
    logic        cfg_sym_we = 1'b0;
    logic [7:0]  cfg_sym_addr = '0;
    logic [7:0]  cfg_sym_data = '0;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_total_bits = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_count;
    logic [31:0] out_syms;
    logic        busy;

    huff_spec_dec dut (.*);

    always #4 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int lens [256];
    int codes [256];
    int firstc [13];
    int cntc [13];
    int basec [13];
    int tabv [256];
    int seq [$];
    int sbits [$];
    int words [$];
    int maxcnt;

    function automatic int symval(int i);
        return (i * 7 + 3) & 255;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    // Canonical code: fl>0 gives a flat length, otherwise random lengths within Kraft budget.
    task automatic build_code(int nsym, int fl);
        int budget, cost, l, code, acc;
        int nxt [13];
        budget = 4096;
        for (int i = 0; i < nsym; i++) begin
            if (fl > 0) l = fl;
            else begin
                l = 2 + $urandom % 11;
                cost = 1 << (12 - l);
                while (cost > budget - (nsym - 1 - i)) begin
                    l++;
                    cost = cost >> 1;
                end
                budget -= cost;
            end
            lens[i] = l;
        end
        for (int j = 0; j < 13; j++) cntc[j] = 0;
        for (int i = 0; i < nsym; i++) cntc[lens[i]]++;
        code = 0;
        acc = 0;
        for (int j = 1; j <= 12; j++) begin
            code = (code + cntc[j-1]) << 1;
            firstc[j] = code;
            nxt[j] = code;
            basec[j] = acc;
            acc += cntc[j];
        end
        for (int i = 0; i < nsym; i++) begin
            codes[i] = nxt[lens[i]];
            nxt[lens[i]]++;
            tabv[basec[lens[i]] + codes[i] - firstc[lens[i]]] = symval(i);
        end
        @(negedge clk);
        for (int j = 1; j <= 12; j++) begin
            cfg_len_we = 1'b1; cfg_len_sel = 4'(j);
            cfg_first = 12'(firstc[j]); cfg_count = 9'(cntc[j]); cfg_base = 8'(basec[j]);
            @(negedge clk);
        end
        cfg_len_we = 1'b0;
        for (int s = 0; s < acc; s++) begin
            cfg_sym_we = 1'b1; cfg_sym_addr = 8'(s); cfg_sym_data = 8'(tabv[s]);
            @(negedge clk);
        end
        cfg_sym_we = 1'b0;
    endtask

    task automatic encode();
        int w, total;
        sbits.delete();
        words.delete();
        foreach (seq[i]) begin
            for (int b = lens[seq[i]] - 1; b >= 0; b--) sbits.push_back((codes[seq[i]] >> b) & 1);
        end
        total = sbits.size();
        for (int k = 0; k < (total + 31) / 32; k++) begin
            w = 0;
            for (int j = 0; j < 32; j++)
                w = (w << 1) | ((k * 32 + j < total) ? sbits[k * 32 + j] : int'($urandom % 2));
            words.push_back(w);
        end
    endtask

    task automatic run_stream(string tag, int pin, int pout);
        int wptr, ep, cyc, hcnt, hsym, nw, nexp;
        bit held;
        nw = words.size();
        nexp = seq.size();
        wptr = 0; ep = 0; cyc = 0; held = 0; hcnt = 0; hsym = 0;
        maxcnt = 0;
        @(negedge clk);
        cfg_start = 1'b1;
        cfg_total_bits = 32'(sbits.size());
        @(negedge clk);
        cfg_start = 1'b0;
        forever begin
            in_valid  = (wptr < nw) ? (($urandom % 100) < pin) : 1'b1;
            in_data   = (wptr < nw) ? 32'(words[wptr]) : 32'hDEAD_BEEF;
            out_ready = ($urandom % 100) < pout;
            #1;
            if (held)
                chk(out_valid && out_count == 3'(hcnt) && out_syms == 32'(hsym),
                    "R7 stalled batch held", int'(out_syms), hsym);
            if (out_valid) begin
                chk(out_count >= 1 && out_count <= 4, "R3 lane count range", int'(out_count), 1);
                if (out_ready) begin
                    if (int'(out_count) > maxcnt) maxcnt = int'(out_count);
                    for (int k = 0; k < int'(out_count); k++) begin
                        if (ep < nexp) begin
                            chk(int'(out_syms[8*k +: 8]) == symval(seq[ep]),
                                $sformatf("%s lane order R3 sym %0d", tag, ep),
                                int'(out_syms[8*k +: 8]), symval(seq[ep]));
                        end else begin
                            chk(1'b0, "R6 symbol past end", ep, nexp);
                        end
                        ep++;
                    end
                end
            end
            held = out_valid && !out_ready;
            hcnt = int'(out_count);
            hsym = int'(out_syms);
            if (in_valid && in_ready) begin
                if (wptr < nw) wptr++;
                else chk(1'b0, "R8 word beyond stream accepted", 1, 0);
            end
            if (!busy && !out_valid) break;
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "R6 stream did not finish", ep, nexp);
                break;
            end
            @(negedge clk);
        end
        chk(ep == nexp, "R6 symbol total", ep, nexp);
        chk(wptr == nw, "R8 words consumed", wptr, nw);
        chk(!in_ready, "R8 ready low after end", int'(in_ready), 0);
        in_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!out_valid, "R9 reset out_valid", int'(out_valid), 0);
        chk(out_count == 0, "R9 reset out_count", int'(out_count), 0);
        chk(!in_ready, "R9 reset in_ready", int'(in_ready), 0);
        chk(!busy, "R9 reset busy", int'(busy), 0);
        rst_n = 1'b1;

        // R5: configured but not started, words offered.
        build_code(8, 3);
        in_valid = 1'b1;
        in_data = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        chk(!in_ready, "R5 holdoff in_ready", int'(in_ready), 0);
        chk(!out_valid, "R5 holdoff out_valid", int'(out_valid), 0);
        chk(!busy, "R5 holdoff busy", int'(busy), 0);
        in_valid = 1'b0;

        // R2: flat 3-bit code, symbol i has code i, known order.
        seq.delete();
        for (int i = 0; i < 40; i++) seq.push_back((i * 5 + 1) % 8);
        encode();
        run_stream("R2", 100, 100);

        // R10: 1-bit code, four starts 0..3 fit the window.
        build_code(2, 1);
        seq.delete();
        for (int i = 0; i < 200; i++) seq.push_back(int'($urandom % 2));
        encode();
        run_stream("R10", 100, 100);
        chk(maxcnt == 4, "R10 four per cycle", maxcnt, 4);

        // R4: flat 12-bit code, starts 0 and 12 only (24 >= 16).
        build_code(256, 12);
        seq.delete();
        for (int i = 0; i < 120; i++) seq.push_back(int'($urandom % 256));
        encode();
        run_stream("R4", 100, 100);
        chk(maxcnt == 2, "R4 offset limit", maxcnt, 2);

        // R1: random canonical codes, random stalls on both sides.
        for (int t = 0; t < 6; t++) begin
            int n;
            n = 2 + int'($urandom % 255);
            build_code(n, 0);
            seq.delete();
            for (int i = 0; i < 150 + int'($urandom % 300); i++) seq.push_back(int'($urandom % n));
            encode();
            run_stream("R1", 40 + 10 * t, 30 + 12 * t);
        end
        finish_run();
    end
endmodule